// File: doc/BRIEF.md
# Comparator Output Conditioning Pipeline

This block sits behind an analog comparator and turns its raw decision bit into two clean digital outputs. The raw bit first passes a polarity stage, then an optional window latch that tracks the input only while a strobe is high, then an optional sampling stage. The sampling stage is clocked by either the strobe's rising edges or an internal period divider. It acts as a plain sample-and-hold or as a consecutive-agreement filter, depending on the sample count. The window path feeds the pad output. The conditioned output carries the filtered value, or the pad value when the output selector requests it.

One set of configuration inputs picks the operating mode. The modes are continuous, strobe-sampled, divider-sampled, filtered, windowed, windowed-resampled and windowed-filtered. Each mode is a choice of which stages are chained and which are bypassed. Two controllers run the sampling stage. The divider controller has the states DIV_HALT and DIV_RUN. It moves DIV_HALT to DIV_RUN once the filter leaves its reset configuration with a nonzero period, and returns to DIV_HALT on reset configuration or period zero. The filter controller has the states FLT_BYPASS, FLT_STEADY and FLT_CONFIRM. It moves FLT_BYPASS to FLT_STEADY when enabled with a nonzero count. It moves FLT_STEADY to FLT_CONFIRM on a differing sample when the count exceeds 1. It returns FLT_CONFIRM to FLT_STEADY on a matching sample (abort) or once enough agreeing samples arrive (commit). Any state goes to FLT_BYPASS when the block is disabled or the count is 0. Rising and falling edges of the conditioned output set sticky flags, and these drive an interrupt through per-flag enables.

Top module: `cmpout_cond`

## Requirements
- R1: With `en`=0, `pad_out` and `cond_out` are 0.
- R2: With `en`=1 and `win_en`=0, `pad_out` equals `raw ^ inv` combinationally.
- R3: With `en`=1 and `filt_cnt`=0, `cond_out` equals `pad_out` combinationally (continuous mode).
- R4: With `en`=1 and `win_en`=1, `pad_out` shows `raw ^ inv` as latched on the last clock edge at which `strobe` was 1, and holds it while `strobe` is 0.
- R5: With `samp_ext`=1, a sample is taken in each clock cycle in which `strobe` is 1 and was 0 in the previous cycle; a strobe held high gives one sample only.
- R6: With `samp_ext`=0, samples come from a divider every `filt_per` clocks; with `filt_cnt`=1 and a constant input, `cond_out` first updates on the (`filt_per`+1)th rising edge after leaving the reset configuration; `filt_per`=0 gives no samples.
- R7: With `filt_cnt`=1 and `out_sel`=0, `cond_out` takes the `pad_out` value of a sample cycle at that cycle's clock edge and holds it otherwise.
- R8: With `filt_cnt`>1 and `out_sel`=0, `cond_out` changes only after `filt_cnt` consecutive samples all differ from it; a sample equal to it restarts the count.
- R9: The reset configuration (`samp_ext`=0 and `filt_cnt`=0, or `en`=0) clears the held filter value to 0 and restarts the divider phase.
- R10: With `en`=1 and `out_sel`=1, `cond_out` equals `pad_out`.
- R11: A 0-to-1 (1-to-0) change of `cond_out` between consecutive clock samples sets `rise_flag` (`fall_flag`) from the next cycle; the flag stays set until a cycle with `rise_clr` (`fall_clr`) at 1, and a new edge in that same cycle keeps it set; both flags reset to 0.
- R12: `irq` is 1 exactly when (`rise_flag` and `rise_ie`) or (`fall_flag` and `fall_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe | input | 1 | External window / sample strobe, synchronous to clk |
| raw | input | 1 | Raw comparator decision bit |
| en | input | 1 | Block enable |
| inv | input | 1 | Invert the raw bit |
| win_en | input | 1 | Enable window latch on the pad path |
| samp_ext | input | 1 | 1: strobe edges clock the filter; 0: internal divider |
| filt_cnt | input | CNT_W | Sample count: 0 off, 1 sample-hold, >1 filter |
| filt_per | input | PER_W | Divider period in clocks, 0 stops sampling |
| out_sel | input | 1 | 1: conditioned output bypasses the filter |
| rise_ie | input | 1 | Rising-flag interrupt enable |
| fall_ie | input | 1 | Falling-flag interrupt enable |
| rise_clr | input | 1 | Write-one clear pulse for rising flag |
| fall_clr | input | 1 | Write-one clear pulse for falling flag |
| pad_out | output | 1 | Pad-side conditioned output |
| cond_out | output | 1 | Internal conditioned output |
| rise_flag | output | 1 | Sticky rising-edge flag |
| fall_flag | output | 1 | Sticky falling-edge flag |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `strobe`, `raw` and all configuration inputs change only between clock edges. They also assume that `filt_cnt`, `filt_per` and `samp_ext` change only while the block is in its reset configuration, so the window and filter history they check is never overwritten mid-count. The stimulus drives every input half a cycle away from the active edge. Between two filter settings it always holds `samp_ext`=0 and `filt_cnt`=0 for two cycles. Inversion, window and output-select changes are applied together with the filter settings.

// File: rtl/cmpcond_pkg.sv
package cmpcond_pkg;

    typedef enum logic [1:0] {
        FLT_BYPASS  = 2'd0,
        FLT_STEADY  = 2'd1,
        FLT_CONFIRM = 2'd2
    } flt_state_t;

    typedef enum logic {
        DIV_HALT = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;

endpackage

// File: rtl/cmpcond_divider.sv
module cmpcond_divider
    import cmpcond_pkg::*;
#(
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PER_W-1:0] period,
    output logic             tick
);

    localparam logic [PER_W-1:0] ONE  = PER_W'(1);
    localparam logic [PER_W-1:0] ZERO = '0;

    div_state_t       st_q, st_n;
    logic [PER_W-1:0] cnt_q, cnt_n;
    logic             live;
    logic             at_end;

    assign live   = !clear && (period != ZERO);
    assign at_end = (cnt_q == ZERO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DIV_HALT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // next state and counter
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            DIV_HALT: begin
                cnt_n = period - ONE;
                if (live) begin
                    st_n = DIV_RUN;
                end
            end
            DIV_RUN: begin
                if (!live) begin
                    st_n  = DIV_HALT;
                    cnt_n = period - ONE;
                end else if (at_end) begin
                    cnt_n = period - ONE;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end
            default: begin
                st_n  = DIV_HALT;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        tick = 1'b0;
        unique case (st_q)
            DIV_HALT: tick = 1'b0;
            DIV_RUN:  tick = live && at_end;
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmpcond_filter.sv
module cmpcond_filter
    import cmpcond_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             tick,
    input  logic             sample,
    input  logic [CNT_W-1:0] need,
    output logic             held
);

    localparam int AW = CNT_W + 1;
    localparam logic [AW-1:0] A_ONE = AW'(1);

    flt_state_t      st_q, st_n;
    logic            held_n;
    logic [AW-1:0]   agree_q, agree_n;
    logic [AW-1:0]   need_x;
    logic [AW-1:0]   agree_inc;
    logic            differs;
    logic            single;

    assign need_x    = {1'b0, need};
    assign agree_inc = agree_q + A_ONE;
    assign differs   = (sample != held);
    assign single    = (need_x == A_ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FLT_BYPASS;
            held    <= 1'b0;
            agree_q <= '0;
        end else begin
            st_q    <= st_n;
            held    <= held_n;
            agree_q <= agree_n;
        end
    end

    // next state
    always_comb begin
        st_n = st_q;
        if (bypass) begin
            st_n = FLT_BYPASS;
        end else begin
            unique case (st_q)
                FLT_BYPASS:  st_n = FLT_STEADY;
                FLT_STEADY: begin
                    if (tick && differs && !single) begin
                        st_n = FLT_CONFIRM;
                    end
                end
                FLT_CONFIRM: begin
                    if (tick && (!differs || (agree_inc >= need_x))) begin
                        st_n = FLT_STEADY;
                    end
                end
                default: st_n = FLT_BYPASS;
            endcase
        end
    end

    // held value and agreement count
    always_comb begin
        held_n  = held;
        agree_n = agree_q;
        if (bypass) begin
            held_n  = 1'b0;
            agree_n = '0;
        end else begin
            unique case (st_q)
                FLT_BYPASS: begin
                    held_n  = 1'b0;
                    agree_n = '0;
                end
                FLT_STEADY: begin
                    if (tick && differs) begin
                        if (single) begin
                            held_n = sample;
                        end else begin
                            agree_n = A_ONE;
                        end
                    end
                end
                FLT_CONFIRM: begin
                    if (tick) begin
                        if (!differs) begin
                            agree_n = '0;
                        end else if (agree_inc >= need_x) begin
                            held_n  = sample;
                            agree_n = '0;
                        end else begin
                            agree_n = agree_inc;
                        end
                    end
                end
                default: begin
                    held_n  = 1'b0;
                    agree_n = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cmpcond_edges.sv
module cmpcond_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_clr,
    input  logic fall_clr,
    input  logic rise_ie,
    input  logic fall_ie,
    output logic rise_flag,
    output logic fall_flag,
    output logic irq
);

    logic prev_q;
    logic up, down;

    assign up   = level && !prev_q;
    assign down = !level && prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            rise_flag <= 1'b0;
            fall_flag <= 1'b0;
        end else begin
            prev_q    <= level;
            rise_flag <= up || (rise_flag && !rise_clr);
            fall_flag <= down || (fall_flag && !fall_clr);
        end
    end

    assign irq = (rise_flag && rise_ie) || (fall_flag && fall_ie);

endmodule

// File: rtl/cmpout_cond.sv
module cmpout_cond #(
    parameter int CNT_W = 3,
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             raw,
    input  logic             en,
    input  logic             inv,
    input  logic             win_en,
    input  logic             samp_ext,
    input  logic [CNT_W-1:0] filt_cnt,
    input  logic [PER_W-1:0] filt_per,
    input  logic             out_sel,
    input  logic             rise_ie,
    input  logic             fall_ie,
    input  logic             rise_clr,
    input  logic             fall_clr,
    output logic             pad_out,
    output logic             cond_out,
    output logic             rise_flag,
    output logic             fall_flag,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_OFF = '0;

    logic pol;
    logic win_q;
    logic strobe_q;
    logic cnt_off;
    logic div_clear;
    logic flt_bypass;
    logic div_tick;
    logic ext_tick;
    logic flt_tick;
    logic flt_held;
    logic flt_out;

    assign pol        = raw ^ inv;
    assign cnt_off    = (filt_cnt == CNT_OFF);
    assign div_clear  = !en || (!samp_ext && cnt_off);
    assign flt_bypass = !en || cnt_off;

    // window latch and strobe history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
            if (strobe) begin
                win_q <= pol;
            end
        end
    end

    assign pad_out  = en && (win_en ? win_q : pol);
    assign ext_tick = strobe && !strobe_q;
    assign flt_tick = samp_ext ? ext_tick : div_tick;

    cmpcond_divider #(.PER_W(PER_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (div_clear),
        .period (filt_per),
        .tick   (div_tick)
    );

    cmpcond_filter #(.CNT_W(CNT_W)) u_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .bypass (flt_bypass),
        .tick   (flt_tick),
        .sample (pad_out),
        .need   (filt_cnt),
        .held   (flt_held)
    );

    assign flt_out  = cnt_off ? pad_out : flt_held;
    assign cond_out = en && (out_sel ? pad_out : flt_out);

    cmpcond_edges u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (cond_out),
        .rise_clr  (rise_clr),
        .fall_clr  (fall_clr),
        .rise_ie   (rise_ie),
        .fall_ie   (fall_ie),
        .rise_flag (rise_flag),
        .fall_flag (fall_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/cmpcond_chk.sv
module cmpcond_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe,
    input logic             raw,
    input logic             en,
    input logic             inv,
    input logic             win_en,
    input logic [CNT_W-1:0] filt_cnt,
    input logic             out_sel,
    input logic             rise_clr,
    input logic             pad_out,
    input logic             cond_out,
    input logic             rise_flag
);

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!pad_out && !cond_out)); // R1

    AST_WIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && win_en && strobe) |=> (!(en && win_en) || (pad_out == $past(raw ^ inv)))); // R4

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && win_en && !strobe) |=> (!(en && win_en) || $stable(pad_out))); // R4

    AST_CONT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (filt_cnt == '0)) |-> (cond_out == pad_out)); // R3

    AST_OUTSEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && out_sel) |-> (cond_out == pad_out)); // R10

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cond_out) |=> rise_flag); // R11

    AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_flag && !rise_clr) |=> rise_flag); // R11

endmodule

bind cmpout_cond cmpcond_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .raw       (raw),
    .en        (en),
    .inv       (inv),
    .win_en    (win_en),
    .filt_cnt  (filt_cnt),
    .out_sel   (out_sel),
    .rise_clr  (rise_clr),
    .pad_out   (pad_out),
    .cond_out  (cond_out),
    .rise_flag (rise_flag)
);

// File: tb/cmpout_cond_bench.sv
`timescale 1ns/1ps
module cmpout_cond_bench;

    localparam int CNT_W = 3;
    localparam int PER_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0, raw = 1'b0, en = 1'b0, inv = 1'b0, win_en = 1'b0;
    logic samp_ext = 1'b0, out_sel = 1'b0;
    logic [CNT_W-1:0] filt_cnt = '0;
    logic [PER_W-1:0] filt_per = '0;
    logic rise_ie = 1'b0, fall_ie = 1'b0, rise_clr = 1'b0, fall_clr = 1'b0;
    logic pad_out, cond_out, rise_flag, fall_flag, irq;

    always #2.5 clk = ~clk;

    cmpout_cond #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmpout_cond (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .raw(raw), .en(en), .inv(inv),
        .win_en(win_en), .samp_ext(samp_ext), .filt_cnt(filt_cnt), .filt_per(filt_per),
        .out_sel(out_sel), .rise_ie(rise_ie), .fall_ie(fall_ie), .rise_clr(rise_clr),
        .fall_clr(fall_clr), .pad_out(pad_out), .cond_out(cond_out),
        .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // reference state, derived from the requirements
    logic m_wq = 0, m_sq = 0, m_drun = 0, m_fq = 0, m_prev = 0, m_rf = 0, m_ff = 0;
    logic [PER_W-1:0] m_dc = '0;
    int m_fst = 0;
    int m_ag = 0;
    logic e_pad, e_cond, e_irq;

    function automatic logic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_eval();
        logic pol;
        pol = raw ^ inv;
        e_pad  = en && (win_en ? m_wq : pol);
        e_cond = en && (out_sel ? e_pad : ((filt_cnt == 0) ? e_pad : m_fq));
        e_irq  = (m_rf && rise_ie) || (m_ff && fall_ie);
    endtask

    task automatic model_update();
        logic clear, byp, live, tick;
        logic n_fq, n_drun;
        logic [PER_W-1:0] n_dc;
        int n_fst, n_ag;
        model_eval();
        clear = !en || (!samp_ext && filt_cnt == 0);
        byp   = !en || filt_cnt == 0;
        live  = !clear && filt_per != 0;
        tick  = samp_ext ? (strobe && !m_sq) : (m_drun && live && m_dc == 0);
        // divider
        n_drun = m_drun; n_dc = m_dc;
        if (!m_drun) begin n_dc = filt_per - 1; n_drun = live; end
        else if (!live) begin n_drun = 0; n_dc = filt_per - 1; end
        else if (m_dc == 0) n_dc = filt_per - 1;
        else n_dc = m_dc - 1;
        // filter
        n_fst = m_fst; n_fq = m_fq; n_ag = m_ag;
        if (byp || m_fst == 0) begin
            n_fq = 0; n_ag = 0; n_fst = byp ? 0 : 1;
        end else if (tick && e_pad != m_fq) begin
            if (filt_cnt == 1) n_fq = e_pad;
            else if (m_ag + 1 >= int'(filt_cnt) && m_fst == 2) begin
                n_fq = e_pad; n_ag = 0; n_fst = 1;
            end else begin
                n_ag = (m_fst == 2) ? m_ag + 1 : 1; n_fst = 2;
            end
        end else if (tick) begin
            n_ag = 0; n_fst = 1;
        end
        // edges
        m_rf = (e_cond && !m_prev) || (m_rf && !rise_clr);
        m_ff = (!e_cond && m_prev) || (m_ff && !fall_clr);
        m_prev = e_cond;
        if (strobe) m_wq = raw ^ inv;
        m_sq = strobe;
        m_drun = n_drun; m_dc = n_dc;
        m_fst = n_fst; m_fq = n_fq; m_ag = n_ag;
    endtask

    function automatic string tag_pad();
        if (!en) return "R1";
        if (win_en) return "R4";
        return "R2";
    endfunction

    function automatic string tag_cond();
        if (!en) return "R1";
        if (out_sel) return "R10";
        if (filt_cnt == 0) return "R3";
        if (filt_cnt == 1) return "R7";
        return "R8";
    endfunction

    // compare all outputs with the reference, then advance one clock
    task automatic step();
        #1;
        model_eval();
        chk(tag_pad(), pad_out, e_pad);
        chk(tag_cond(), cond_out, e_cond);
        chk("R11", rise_flag, m_rf);
        chk("R11", fall_flag, m_ff);
        chk("R12", irq, e_irq);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic to_reset_cfg();
        samp_ext = 0; filt_cnt = 0; strobe = 0;
        step(); step();
    endtask

    task automatic pulse();
        strobe = 1; step();
        strobe = 0; step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", pad_out, 1'b0);
        chk("R1", cond_out, 1'b0);
        chk("R11", rise_flag, 1'b0);
        chk("R12", irq, 1'b0);
        rst_n = 1;
        @(negedge clk);

        // disabled with random activity
        for (int i = 0; i < 40; i++) begin
            raw = rnd(); strobe = rnd(); inv = rnd(); win_en = rnd();
            step();
        end

        en = 1;
        // near-exhaustive sweep of mode combinations
        for (int iv = 0; iv < 2; iv++)
        for (int w = 0; w < 2; w++)
        for (int se = 0; se < 2; se++)
        for (int os = 0; os < 2; os++)
        for (int c = 0; c < 4; c++)
        for (int p = 0; p < 4; p++) begin
            if (se == 1 && p != 0) continue;
            to_reset_cfg();
            inv = iv[0]; win_en = w[0]; out_sel = os[0];
            rise_ie = rnd(); fall_ie = rnd();
            samp_ext = se[0]; filt_cnt = CNT_W'(c); filt_per = PER_W'(p);
            for (int k = 0; k < 48; k++) begin
                raw = (k % 7 < 4) ? rnd() | rnd() : rnd() & rnd();
                strobe = rnd();
                rise_clr = rnd() & rnd() & rnd();
                fall_clr = rnd() & rnd() & rnd();
                step();
            end
            rise_clr = 0; fall_clr = 0;
        end

        // R5: strobe edges clock the sample-hold
        inv = 0; win_en = 0; out_sel = 0;
        to_reset_cfg();
        samp_ext = 1; filt_cnt = 1; raw = 1; strobe = 0;
        step(); step();
        chk("R5", cond_out, 1'b0);
        strobe = 1; step();
        chk("R5", cond_out, 1'b1);
        raw = 0; step(); step(); step();
        chk("R5", cond_out, 1'b1);
        strobe = 0; step();
        strobe = 1; step();
        chk("R5", cond_out, 1'b0);

        // R6: divider timing
        to_reset_cfg();
        raw = 1; filt_cnt = 1; filt_per = 3;
        step(); step(); step();
        chk("R6", cond_out, 1'b0);
        step();
        chk("R6", cond_out, 1'b1);
        raw = 0; to_reset_cfg();
        raw = 1; filt_cnt = 1; filt_per = 1;
        step();
        chk("R6", cond_out, 1'b0);
        step();
        chk("R6", cond_out, 1'b1);
        raw = 0; to_reset_cfg();
        raw = 1; filt_cnt = 1; filt_per = 0;
        for (int i = 0; i < 12; i++) step();
        chk("R6", cond_out, 1'b0);

        // R8: three agreeing samples, with an abort
        to_reset_cfg();
        samp_ext = 1; filt_cnt = 3; raw = 1;
        step();
        pulse(); pulse();
        chk("R8", cond_out, 1'b0);
        raw = 0; pulse();
        raw = 1; pulse(); pulse();
        chk("R8", cond_out, 1'b0);
        pulse();
        chk("R8", cond_out, 1'b1);

        // R9: reset configuration clears the held value
        raw = 0;
        to_reset_cfg();
        samp_ext = 1; filt_cnt = 1; strobe = 0;
        step();
        chk("R9", cond_out, 1'b0);

        // R4: window latch
        to_reset_cfg();
        win_en = 1;
        raw = 0; strobe = 1; step();
        chk("R4", pad_out, 1'b0);
        raw = 1; strobe = 0; step(); step(); step();
        chk("R4", pad_out, 1'b0);
        strobe = 1; step();
        chk("R4", pad_out, 1'b1);
        win_en = 0; strobe = 0; raw = 0;
        step(); step();

        // R11 / R12: flags and interrupt
        rise_ie = 1; fall_ie = 0; rise_clr = 1; fall_clr = 1; step();
        rise_clr = 0; fall_clr = 0;
        raw = 1; step();
        chk("R11", rise_flag, 1'b1);
        chk("R12", irq, 1'b1);
        rise_clr = 1; step(); rise_clr = 0;
        chk("R11", rise_flag, 1'b0);
        chk("R12", irq, 1'b0);
        raw = 0; step();
        chk("R11", fall_flag, 1'b1);
        chk("R12", irq, 1'b0);
        raw = 1; rise_clr = 1; step(); rise_clr = 0;
        chk("R11", rise_flag, 1'b1);
        step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule